// File: doc/BRIEF.md
# Sixteen-Channel Nested Priority Interrupt Controller

This unit lets sixteen request channels break into a running program. A request can come from a device finishing its work, from an external line, or from the program itself. Each request is held in a pending latch until it is taken. At an instruction boundary, with breaks enabled, the unit picks the pending channel of highest priority. It takes that channel only if it outranks every channel already in service. It then holds the CPU and spends four memory cycles on entry. Three cycles store the accumulator, the I/O register and the program counter into the channel's four-word save block. The fourth cycle reads the handler instruction from the last word of the block and hands it to the CPU.

When a handler finishes, the CPU pulses a dismiss strobe. The unit then runs a six-cycle return on the highest-priority channel in service. Three read cycles hand the saved words back to the CPU, and three settle cycles follow with the memory port idle. At the end of the return the channel's in-service bit is cleared, which opens the way again for lower levels. A higher-priority channel may nest over a handler that is running. A request at the same level or a lower one waits.

Top module: `prio_break_ctrl`

## Requirements
- R1: After reset no channel is pending or in service, and `hold_o`, `mem_req_o`, `cpu_exec_o` and `cpu_ld_o` are all low.
- R2: A pulse on `req_i[n]`, or on `sw_req_i` with `sw_ch_i`=n, sets channel n pending. The channel stays pending until it is taken, whatever the state of `enable_i`.
- R3: A break is taken only in a cycle where the sequencer is idle, `enable_i` and `insn_done_i` are high, and some channel is pending.
- R4: Channel 0 has the highest priority and channel 15 the lowest. Of the pending channels, the one with the lowest index is chosen.
- R5: Entry on channel n lasts four cycles, starting the cycle after the break is taken. The first three cycles write `ac_i`, `io_i` and `pc_i` to addresses 4n, 4n+1 and 4n+2. The fourth cycle reads address 4n+3 with `cpu_exec_o` high and `cpu_data_o` equal to the word read.
- R6: `active_o[n]` is set from the cycle after channel n is taken until its return completes.
- R7: A dismiss while idle, with any channel in service, starts a six-cycle return on the lowest-index channel in service. Cycles 0 to 2 read offsets 0, 1 and 2 of its block. In those cycles `cpu_ld_o` is 001, 010 and 100 (accumulator, I/O, program counter) and `cpu_data_o` carries the word read. Cycles 3 to 5 leave memory idle, and then the in-service bit clears.
- R8: A dismiss takes precedence over a break that could be taken in the same cycle. A dismiss with no channel in service is ignored.
- R9: A new request for the channel being taken, arriving in the very cycle the break is taken, stays pending.
- R10: With `enable_i` low no break is taken, while dismiss still works.
- R11: A pending channel is taken only if its index is lower than that of every channel in service. Other pending channels wait until returns lift the blocking levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Device and external request pulses, one per channel |
| sw_req_i | input | 1 | Program-raised request strobe |
| sw_ch_i | input | 4 | Channel of the program-raised request |
| enable_i | input | 1 | Global break enable |
| insn_done_i | input | 1 | CPU is at an instruction boundary |
| dismiss_i | input | 1 | Handler finished; start a return |
| ac_i | input | 18 | CPU accumulator |
| io_i | input | 18 | CPU I/O register |
| pc_i | input | 18 | CPU program counter |
| hold_o | output | 1 | CPU held while a sequence runs |
| cpu_exec_o | output | 1 | Execute `cpu_data_o` as the next instruction |
| cpu_ld_o | output | 3 | Restore strobe: bit 0 accumulator, bit 1 I/O, bit 2 program counter |
| cpu_data_o | output | 18 | Word for the CPU during fetch or restore |
| mem_req_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 18 | Memory write data |
| mem_rdata_i | input | 18 | Memory read data, valid in the same cycle |
| active_o | output | 16 | In-service bit per channel |

## Verification
Two collisions are provoked on purpose. In the first, a dismiss strobe meets a pending channel that could otherwise be taken in the same cycle. The next cycle must show a return read at the blocking channel's base address, and not a save write. In the second, a fresh request lands on the very channel being taken in that cycle. That request must survive: after the handler returns, the same channel is taken a second time. A behavioural model of pending sets, in-service sets and saved words judges every output on every clock. Directed checks also look at the in-service vector at these points.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ENTER, SEQ_LEAVE} seq_mode_e;
  localparam int ENTER_LAST = 3;
  localparam int LEAVE_LAST = 5;
  localparam int SAVE_WORDS = 3;
endpackage

// File: rtl/pbi_first_one.sv
module pbi_first_one #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pbi_flag_bank.sv
module pbi_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/pbi_seq.sv
module pbi_seq
  import pbi_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 18,
  parameter int AW = 12,
  localparam int CW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          insn_done_i,
  input  logic          dismiss_i,
  input  logic          pend_found_i,
  input  logic [CW-1:0] pend_idx_i,
  input  logic          act_found_i,
  input  logic [CW-1:0] act_idx_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] io_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [N-1:0]  take_o,
  output logic [N-1:0]  release_o,
  output logic          hold_o,
  output logic          cpu_exec_o,
  output logic [2:0]    cpu_ld_o,
  output logic [DW-1:0] cpu_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  seq_mode_e     mode_q;
  logic [2:0]    step_q;
  logic [CW-1:0] ch_q;
  logic idle, go_ret, go_brk, outranks, last_enter, last_leave, in_save, in_restore;

  assign idle       = (mode_q == SEQ_IDLE);
  assign outranks   = !act_found_i || (pend_idx_i < act_idx_i);
  assign go_ret     = idle && dismiss_i && act_found_i;
  assign go_brk     = idle && !go_ret && enable_i && insn_done_i && pend_found_i && outranks;
  assign last_enter = (mode_q == SEQ_ENTER) && (step_q == 3'(ENTER_LAST));
  assign last_leave = (mode_q == SEQ_LEAVE) && (step_q == 3'(LEAVE_LAST));
  assign in_save    = (mode_q == SEQ_ENTER) && (step_q < 3'(SAVE_WORDS));
  assign in_restore = (mode_q == SEQ_LEAVE) && (step_q < 3'(SAVE_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= SEQ_IDLE;
      step_q <= '0;
      ch_q   <= '0;
    end else if (go_ret) begin
      mode_q <= SEQ_LEAVE;
      step_q <= '0;
      ch_q   <= act_idx_i;
    end else if (go_brk) begin
      mode_q <= SEQ_ENTER;
      step_q <= '0;
      ch_q   <= pend_idx_i;
    end else if (last_enter || last_leave) begin
      mode_q <= SEQ_IDLE;
      step_q <= '0;
    end else if (!idle) begin
      step_q <= step_q + 3'd1;
    end
  end

  assign take_o    = go_brk ? (N'(1) << pend_idx_i) : '0;
  assign release_o = last_leave ? (N'(1) << ch_q) : '0;

  assign hold_o     = !idle;
  assign mem_req_o  = (mode_q == SEQ_ENTER) || in_restore;
  assign mem_we_o   = in_save;
  assign mem_addr_o = mem_req_o ? AW'({ch_q, step_q[1:0]}) : '0;
  assign cpu_exec_o = last_enter;
  assign cpu_ld_o   = in_restore ? (3'b001 << step_q[1:0]) : 3'b000;
  assign cpu_data_o = (cpu_exec_o || in_restore) ? mem_rdata_i : '0;

  always_comb begin
    mem_wdata_o = '0;
    if (in_save) begin
      case (step_q[1:0])
        2'd0:    mem_wdata_o = ac_i;
        2'd1:    mem_wdata_o = io_i;
        default: mem_wdata_o = pc_i;
      endcase
    end
  end
endmodule

// File: rtl/prio_break_ctrl.sv
module prio_break_ctrl #(
  parameter int NUM_CH = 16,
  parameter int DW     = 18,
  parameter int AW     = 12,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              sw_req_i,
  input  logic [CW-1:0]     sw_ch_i,
  input  logic              enable_i,
  input  logic              insn_done_i,
  input  logic              dismiss_i,
  input  logic [DW-1:0]     ac_i,
  input  logic [DW-1:0]     io_i,
  input  logic [DW-1:0]     pc_i,
  output logic              hold_o,
  output logic              cpu_exec_o,
  output logic [2:0]        cpu_ld_o,
  output logic [DW-1:0]     cpu_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [NUM_CH-1:0] active_o
);
  logic [NUM_CH-1:0] new_req, pend, take, release_ch;
  logic              pend_found, act_found;
  logic [CW-1:0]     pend_idx, act_idx;

  assign new_req = req_i | (sw_req_i ? (NUM_CH'(1) << sw_ch_i) : '0);

  pbi_flag_bank #(.N(NUM_CH)) u_pend (
    .clk_i, .rst_ni, .set_i(new_req), .clr_i(take), .flag_o(pend)
  );

  pbi_flag_bank #(.N(NUM_CH)) u_active (
    .clk_i, .rst_ni, .set_i(take), .clr_i(release_ch), .flag_o(active_o)
  );

  pbi_first_one #(.N(NUM_CH)) u_pend_pick (
    .vec_i(pend), .found_o(pend_found), .idx_o(pend_idx)
  );

  pbi_first_one #(.N(NUM_CH)) u_act_pick (
    .vec_i(active_o), .found_o(act_found), .idx_o(act_idx)
  );

  pbi_seq #(.N(NUM_CH), .DW(DW), .AW(AW)) u_seq (
    .clk_i, .rst_ni, .enable_i, .insn_done_i, .dismiss_i,
    .pend_found_i(pend_found), .pend_idx_i(pend_idx),
    .act_found_i(act_found), .act_idx_i(act_idx),
    .ac_i, .io_i, .pc_i, .mem_rdata_i,
    .take_o(take), .release_o(release_ch),
    .hold_o, .cpu_exec_o, .cpu_ld_o, .cpu_data_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );
endmodule

// File: rtl/pbi_chk.sv
module pbi_chk #(
  parameter int N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         enable_i,
  input logic         hold_o,
  input logic         mem_req_o,
  input logic         mem_we_o,
  input logic [1:0]   mem_addr_lo,
  input logic         cpu_exec_o,
  input logic [2:0]   cpu_ld_o,
  input logic [N-1:0] active_o
);
  AST_LD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cpu_ld_o)); // R7
  AST_RESTORE_READS: assert property (@(posedge clk_i) disable iff (!rst_ni) (|cpu_ld_o) |-> (mem_req_o && !mem_we_o)); // R7
  AST_MEM_UNDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o |-> hold_o); // R5
  AST_EXEC_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni) cpu_exec_o |-> (mem_req_o && !mem_we_o && mem_addr_lo == 2'd3)); // R5
  AST_SAVE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni) ($rose(hold_o) && mem_we_o) |=> mem_we_o); // R5
  AST_ENTRY_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni) ($rose(hold_o) && mem_we_o) |-> ($countones(active_o) == $countones($past(active_o)) + 1)); // R6
  AST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) (!enable_i && !hold_o) |=> !(hold_o && mem_we_o)); // R10
endmodule

bind prio_break_ctrl pbi_chk #(.N(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .hold_o(hold_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_lo(mem_addr_o[1:0]),
  .cpu_exec_o(cpu_exec_o), .cpu_ld_o(cpu_ld_o), .active_o(active_o)
);

// File: tb/tb_prio_break_ctrl.sv
module tb_prio_break_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        sw_v = 1'b0;
  logic [3:0]  sw_ch = '0;
  logic        en = 1'b0, insn = 1'b1, dis = 1'b0;
  logic [17:0] ac, io, pc;
  logic        hold_o, cpu_exec_o, mem_req_o, mem_we_o;
  logic [2:0]  cpu_ld_o;
  logic [17:0] cpu_data_o, mem_wdata_o, mem_rdata;
  logic [11:0] mem_addr_o;
  logic [15:0] active_o;
  logic [17:0] mem [0:63];

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  prio_break_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sw_req_i(sw_v), .sw_ch_i(sw_ch),
    .enable_i(en), .insn_done_i(insn), .dismiss_i(dis),
    .ac_i(ac), .io_i(io), .pc_i(pc),
    .hold_o, .cpu_exec_o, .cpu_ld_o, .cpu_data_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i(mem_rdata), .active_o
  );

  function automatic logic [17:0] handler(int n);
    return 18'h10000 + 18'(n);
  endfunction

  // CPU registers and memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      ac <= 18'h00100; io <= 18'h02000; pc <= 18'h00040;
      for (int n = 0; n < 64; n++) mem[n] <= ((n % 4) == 3) ? handler(n / 4) : 18'h0;
    end else begin
      ac <= ac + 18'd7; io <= io + 18'd13; pc <= pc + 18'd1;
      if (mem_req_o && mem_we_o) mem[mem_addr_o[5:0]] <= mem_wdata_o;
    end
  end
  assign mem_rdata = mem[mem_addr_o[5:0]];

  // behavioural reference model
  bit   m_pend [16];
  bit   m_act  [16];
  int   m_mode, m_step, m_ch;
  logic [17:0] saved [16][3];

  function automatic int lowest_pend();
    for (int i = 0; i < 16; i++) if (m_pend[i]) return i;
    return 16;
  endfunction
  function automatic int lowest_act();
    for (int i = 0; i < 16; i++) if (m_act[i]) return i;
    return 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_pend[i] = 0; m_act[i] = 0; end
      m_mode = 0; m_step = 0; m_ch = 0;
    end else begin
      int hp, ha;
      hp = lowest_pend();
      ha = lowest_act();
      if (m_mode == 1 && m_step < 3)
        saved[m_ch][m_step] = (m_step == 0) ? ac : (m_step == 1) ? io : pc;
      if (m_mode == 0) begin
        if (dis && ha < 16) begin
          m_mode = 2; m_step = 0; m_ch = ha;
        end else if (en && insn && hp < ha) begin
          m_mode = 1; m_step = 0; m_ch = hp; m_act[hp] = 1; m_pend[hp] = 0;
        end
      end else if (m_mode == 1) begin
        if (m_step == 3) begin m_mode = 0; m_step = 0; end else m_step++;
      end else begin
        if (m_step == 5) begin m_mode = 0; m_step = 0; m_act[m_ch] = 0; end else m_step++;
      end
      for (int i = 0; i < 16; i++) if (req[i] || (sw_v && sw_ch == 4'(i))) m_pend[i] = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic        e_req, e_we, e_exec;
      logic [2:0]  e_ld;
      logic [11:0] e_addr;
      logic [17:0] e_wd, e_data;
      logic [15:0] e_act;
      e_req  = (m_mode == 1) || (m_mode == 2 && m_step < 3);
      e_we   = (m_mode == 1) && (m_step < 3);
      e_addr = e_req ? 12'(m_ch * 4 + m_step) : 12'h0;
      e_wd   = !e_we ? 18'h0 : (m_step == 0) ? ac : (m_step == 1) ? io : pc;
      e_exec = (m_mode == 1) && (m_step == 3);
      e_ld   = (m_mode == 2 && m_step < 3) ? 3'(1 << m_step) : 3'b000;
      e_data = e_exec ? handler(m_ch) : (e_ld != 0) ? saved[m_ch][m_step] : 18'h0;
      for (int i = 0; i < 16; i++) e_act[i] = m_act[i];
      chk(active_o == e_act, "R6", "active_o", active_o, e_act);
      chk(hold_o == (m_mode != 0), "R3", "hold_o", hold_o, m_mode != 0);
      chk({mem_req_o, mem_we_o, mem_addr_o, mem_wdata_o} == {e_req, e_we, e_addr, e_wd},
          "R5", "mem bus", {mem_req_o, mem_we_o, mem_addr_o, mem_wdata_o}, {e_req, e_we, e_addr, e_wd});
      chk({cpu_exec_o, cpu_ld_o, cpu_data_o} == {e_exec, e_ld, e_data},
          "R7", "cpu side", {cpu_exec_o, cpu_ld_o, cpu_data_o}, {e_exec, e_ld, e_data});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (hold_o) @(negedge clk);
  endtask
  task automatic check_act(input logic [15:0] exp, input string tag);
    @(negedge clk);
    chk(active_o == exp, tag, "active_o", active_o, exp);
  endtask
  task automatic check_now(input logic [15:0] exp, input string tag);
    chk(active_o == exp, tag, "active_o", active_o, exp);
  endtask
  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(active_o == 16'h0 && !hold_o && !mem_req_o && !cpu_exec_o && cpu_ld_o == 3'b0,
        "R1", "reset outputs", {active_o, hold_o, mem_req_o}, 0);
    // R2 R10: requests latch while breaks are disabled
    tick(1);
    req = 16'h0024; tick(1); req = '0;
    tick(3);
    check_act(16'h0000, "R10");
    // R4: lowest index of {2,5} taken
    en = 1'b1; tick(1);
    wait_idle();
    check_act(16'h0004, "R4");
    tick(3);
    check_act(16'h0004, "R11");           // ch5 blocked by ch2
    // R2 software request nests over ch2
    sw_v = 1'b1; sw_ch = 4'd0; tick(1); sw_v = 1'b0;
    tick(1);
    wait_idle();
    check_act(16'h0005, "R2");
    // R7 return of ch0
    dis = 1'b1; tick(1); dis = 1'b0;
    wait_idle();
    check_act(16'h0004, "R7");
    // R8 dismiss beats a takeable ch1 in the same cycle
    en = 1'b0; req = 16'h0002; tick(1); req = '0;
    en = 1'b1; dis = 1'b1; tick(1); dis = 1'b0;
    @(negedge clk);
    chk(mem_req_o && !mem_we_o && mem_addr_o == 12'd8, "R8", "first cycle after collision",
        {mem_req_o, mem_we_o, mem_addr_o}, {1'b1, 1'b0, 12'd8});
    wait_idle();
    check_now(16'h0000, "R7");
    @(posedge clk); #1;
    wait_idle();
    check_now(16'h0002, "R3");
    // return ch1, then ch5 finally taken
    dis = 1'b1; tick(1); dis = 1'b0;
    wait_idle();
    @(posedge clk); #1;
    wait_idle();
    check_now(16'h0020, "R11");
    // R9: fresh request on ch3 in its take cycle
    en = 1'b0; req = 16'h0008; tick(1);
    en = 1'b1; tick(1); req = '0;
    wait_idle();
    check_now(16'h0028, "R6");
    dis = 1'b1; tick(1); dis = 1'b0;
    wait_idle();
    @(posedge clk); #1;
    wait_idle();
    check_now(16'h0028, "R9");
    // unwind
    dis = 1'b1; tick(1); dis = 1'b0;
    wait_idle();
    check_now(16'h0020, "R7");
    dis = 1'b1; tick(1); dis = 1'b0;
    wait_idle();
    check_now(16'h0000, "R7");
    // R8: dismiss with nothing in service is ignored
    dis = 1'b1; tick(1); dis = 1'b0;
    @(negedge clk);
    chk(!hold_o && !mem_req_o, "R8", "idle after stray dismiss", {hold_o, mem_req_o}, 0);
    tick(5);
    summary();
    $finish;
  end
endmodule